// File: doc/BRIEF.md
# Digital Black Level Correction Loop

This block closes a digital offset-correction loop around a pixel sampling front end. On every cycle that is both an update event and an optically black pixel, it takes the gain-normalised 13-bit pixel word and subtracts it from a fixed black target of 64. In a 10-bit view of the same word, that target is 8. The signed difference is divided by a programmable power of two and added into a wide integrating accumulator. The sum is saturated to the accumulator's range rather than allowed to wrap.

The upper 9 bits of the accumulator form the offset code for an external correction DAC. The block drives that code both as a binary word and as a 511-line thermometer pattern.

Update events arrive as single-cycle strobes at a rate well below the pixel rate. A register port reads the 9-bit code and writes it at any time; a write clears the accumulator bits below the code. The integrator can be frozen, in which case only register writes move it. After reset the accumulator sits at mid-scale.

Top module: `blc_loop`

## Requirements
- R1: While reset is asserted, and after its release until the first update or write, the accumulator holds mid-scale 2^(ACC_W-1) (32768 by default), so the code reads 256.
- R2: When `upd_i`, `blk_i` and `loop_en_i` are all high in a cycle without a write, the accumulator takes accumulator + ((64 - `pix_i`) scaled by R3) at that clock edge; a pixel equal to 64 leaves it unchanged.
- R3: `gain_sel_i` value s (0 to 3) divides the signed error by 2^s as an arithmetic right shift rounding toward minus infinity (error +1 with s=3 adds 0, error -1 with s=3 adds -1).
- R4: With `loop_en_i` low, or `blk_i` low, or `upd_i` low, no update takes place and the accumulator holds.
- R5: The updated sum saturates at 0 and at 2^ACC_W-1 (65535 by default) and never wraps.
- R6: A cycle with `reg_wr_i` high loads `reg_wdata_i` into the accumulator's upper 9 bits and zero into all lower bits, whatever the enable state; it wins over an update in the same cycle.
- R7: `code_o` and `reg_rdata_o` both equal accumulator bits [ACC_W-1:ACC_W-9] (bits 15:7 by default).
- R8: Thermometer line `therm_o[i]` is high exactly when `code_o` > i, for i from 0 to 510.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 13 | Gain-normalised pixel word |
| blk_i | input | 1 | Current pixel is optically black |
| upd_i | input | 1 | Update-rate strobe |
| loop_en_i | input | 1 | Integrator enable |
| gain_sel_i | input | 2 | Loop gain shift (divide by 2^value) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 9 | Code to load on a write |
| reg_rdata_o | output | 9 | Code read back |
| code_o | output | 9 | Binary offset code to the DAC |
| therm_o | output | 511 | Thermometer-coded offset code |

## Verification
Every result is due exactly one clock edge after its stimulus. The accumulator is the only register, and the binary code, read-back and thermometer outputs decode from it with no further delay. The bench therefore drives each stimulus at a falling edge, lets one rising edge pass, and samples all three outputs at the next falling edge. The stimulus is removed before the following edge, so the check reflects that one update or write alone. Stimuli are chosen so that low-bit effects, such as rounding and write clearing, become visible in the 9-bit code one or two steps later.

// File: rtl/blc_pkg.sv
package blc_pkg;
   localparam int BLC_PIX_W    = 13;
   localparam int BLC_ACC_W    = 16;
   localparam int BLC_CODE_W   = 9;
   localparam int BLC_SEL_W    = 2;
   localparam int BLC_TARGET   = 64;
endpackage

// File: rtl/blc_err_scale.sv
module blc_err_scale #(
   parameter int PIX_W  = blc_pkg::BLC_PIX_W,
   parameter int SEL_W  = blc_pkg::BLC_SEL_W,
   parameter int TARGET = blc_pkg::BLC_TARGET,
   localparam int ERR_W = PIX_W + 1
) (
   input  logic [PIX_W-1:0]        pix_i,
   input  logic [SEL_W-1:0]        sel_i,
   output logic signed [ERR_W-1:0] delta_o
);
   localparam int NSTEP = 1 << SEL_W;
   localparam logic [PIX_W-1:0] TGT = PIX_W'(TARGET);

   logic signed [ERR_W-1:0] raw;
   logic signed [ERR_W-1:0] step [NSTEP];

   // signed error: target minus measured level
   assign raw = $signed({1'b0, TGT}) - $signed({1'b0, pix_i});

   // one arithmetic shift per selectable loop gain
   for (genvar k = 0; k < NSTEP; k++) begin : g_step
      assign step[k] = raw >>> k;
   end

   assign delta_o = step[sel_i];
endmodule

// File: rtl/blc_accum.sv
module blc_accum #(
   parameter int ACC_W  = blc_pkg::BLC_ACC_W,
   parameter int CODE_W = blc_pkg::BLC_CODE_W,
   parameter int ERR_W  = blc_pkg::BLC_PIX_W + 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    step_i,
   input  logic                    wr_i,
   input  logic [CODE_W-1:0]       wdata_i,
   input  logic signed [ERR_W-1:0] delta_i,
   output logic [ACC_W-1:0]        acc_o
);
   localparam int SUM_W = ACC_W + 2;
   localparam int LOW_W = ACC_W - CODE_W;
   localparam logic [ACC_W-1:0] MID = ACC_W'(1) << (ACC_W - 1);
   localparam logic [ACC_W-1:0] TOP = '1;

   logic [ACC_W-1:0]        acc_q;
   logic [ACC_W-1:0]        acc_d;
   logic [ACC_W-1:0]        clip;
   logic signed [SUM_W-1:0] sum;

   assign sum = $signed({2'b00, acc_q})
              + $signed({{(SUM_W-ERR_W){delta_i[ERR_W-1]}}, delta_i});

   // saturate: sign bit means below zero, next bit means above full scale
   always_comb begin
      if (sum[SUM_W-1])      clip = '0;
      else if (sum[ACC_W])   clip = TOP;
      else                   clip = sum[ACC_W-1:0];
   end

   // register write wins over a loop update in the same cycle
   always_comb begin
      acc_d = acc_q;
      if (wr_i)         acc_d = {wdata_i, {LOW_W{1'b0}}};
      else if (step_i)  acc_d = clip;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q <= MID;
      else         acc_q <= acc_d;
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/blc_therm.sv
module blc_therm #(
   parameter int CODE_W  = blc_pkg::BLC_CODE_W,
   localparam int LINES  = (1 << CODE_W) - 1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [LINES-1:0]  therm_o
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign therm_o[i] = (code_i > CODE_W'(i));
   end
endmodule

// File: rtl/blc_loop.sv
module blc_loop #(
   parameter int PIX_W  = blc_pkg::BLC_PIX_W,
   parameter int ACC_W  = blc_pkg::BLC_ACC_W,
   parameter int CODE_W = blc_pkg::BLC_CODE_W,
   parameter int SEL_W  = blc_pkg::BLC_SEL_W,
   parameter int TARGET = blc_pkg::BLC_TARGET,
   localparam int LINES = (1 << CODE_W) - 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PIX_W-1:0]  pix_i,
   input  logic              blk_i,
   input  logic              upd_i,
   input  logic              loop_en_i,
   input  logic [SEL_W-1:0]  gain_sel_i,
   input  logic              reg_wr_i,
   input  logic [CODE_W-1:0] reg_wdata_i,
   output logic [CODE_W-1:0] reg_rdata_o,
   output logic [CODE_W-1:0] code_o,
   output logic [LINES-1:0]  therm_o
);
   localparam int ERR_W = PIX_W + 1;

   initial begin
      assert (ACC_W > CODE_W) else $error("ACC_W must exceed CODE_W");
      assert (ACC_W + 2 > ERR_W) else $error("ACC_W too narrow for pixel error");
      assert (TARGET < (1 << PIX_W)) else $error("TARGET outside pixel range");
      assert (SEL_W >= 1 && SEL_W <= 4) else $error("SEL_W out of range");
   end

   logic signed [ERR_W-1:0] delta;
   logic [ACC_W-1:0]        acc_q;
   logic                    step;

   assign step = upd_i & blk_i & loop_en_i;

   blc_err_scale #(.PIX_W(PIX_W), .SEL_W(SEL_W), .TARGET(TARGET)) u_err (
      .pix_i   (pix_i),
      .sel_i   (gain_sel_i),
      .delta_o (delta)
   );

   blc_accum #(.ACC_W(ACC_W), .CODE_W(CODE_W), .ERR_W(ERR_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step),
      .wr_i    (reg_wr_i),
      .wdata_i (reg_wdata_i),
      .delta_i (delta),
      .acc_o   (acc_q)
   );

   assign code_o      = acc_q[ACC_W-1 -: CODE_W];
   assign reg_rdata_o = code_o;

   blc_therm #(.CODE_W(CODE_W)) u_therm (
      .code_i  (code_o),
      .therm_o (therm_o)
   );
endmodule

// File: rtl/blc_loop_chk.sv
module blc_loop_chk #(
   parameter int PIX_W  = 13,
   parameter int ACC_W  = 16,
   parameter int CODE_W = 9,
   parameter int TARGET = 64,
   localparam int LINES = (1 << CODE_W) - 1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [PIX_W-1:0]  pix_i,
   input logic              blk_i,
   input logic              upd_i,
   input logic              loop_en_i,
   input logic              reg_wr_i,
   input logic [CODE_W-1:0] reg_wdata_i,
   input logic [CODE_W-1:0] code_o,
   input logic [LINES-1:0]  therm_o,
   input logic [ACC_W-1:0]  acc
);
   localparam int LOW_W = ACC_W - CODE_W;
   localparam logic [CODE_W-1:0] MIDC = CODE_W'(1) << (CODE_W - 1);
   localparam logic [PIX_W-1:0]  TGT  = PIX_W'(TARGET);

   logic go;
   assign go = upd_i && blk_i && loop_en_i && !reg_wr_i;

   assert_reset_mid_R1: assert property (@(posedge clk_i)
      !rst_ni |=> code_o == MIDC);

   assert_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && pix_i <= TGT) |=> acc >= $past(acc));

   assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && pix_i >= TGT) |=> acc <= $past(acc));

   assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reg_wr_i && !(upd_i && blk_i && loop_en_i)) |=> $stable(acc));

   assert_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_wr_i |=> (code_o == $past(reg_wdata_i)) && (acc[LOW_W-1:0] == '0));

   assert_therm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(therm_o) == int'(code_o));
endmodule

bind blc_loop blc_loop_chk #(
   .PIX_W(PIX_W), .ACC_W(ACC_W), .CODE_W(CODE_W), .TARGET(TARGET)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pix_i       (pix_i),
   .blk_i       (blk_i),
   .upd_i       (upd_i),
   .loop_en_i   (loop_en_i),
   .reg_wr_i    (reg_wr_i),
   .reg_wdata_i (reg_wdata_i),
   .code_o      (code_o),
   .therm_o     (therm_o),
   .acc         (acc_q)
);

// File: tb/blc_loop_tb.sv
`timescale 1ns/1ps
module blc_loop_tb_top;
   localparam int LINES = 511;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic [12:0]      pix_i = '0;
   logic             blk_i = 1'b0;
   logic             upd_i = 1'b0;
   logic             loop_en_i = 1'b0;
   logic [1:0]       gain_sel_i = '0;
   logic             reg_wr_i = 1'b0;
   logic [8:0]       reg_wdata_i = '0;
   logic [8:0]       reg_rdata_o;
   logic [8:0]       code_o;
   logic [LINES-1:0] therm_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk_i = ~clk_i;

   blc_loop dut_i (
      .clk_i, .rst_ni, .pix_i, .blk_i, .upd_i, .loop_en_i, .gain_sel_i,
      .reg_wr_i, .reg_wdata_i, .reg_rdata_o, .code_o, .therm_o
   );

   // {pix, gain_sel, blk, upd, en, expected code}; start from mid-scale 32768
   localparam logic [26:0] VEC [12] = '{
      {13'd64,   2'd0, 1'b1, 1'b1, 1'b1, 9'd256},
      {13'd0,    2'd0, 1'b1, 1'b1, 1'b1, 9'd256},
      {13'd0,    2'd0, 1'b1, 1'b1, 1'b1, 9'd257},
      {13'd1088, 2'd0, 1'b1, 1'b1, 1'b1, 9'd249},
      {13'd1088, 2'd1, 1'b1, 1'b1, 1'b1, 9'd245},
      {13'd1088, 2'd2, 1'b1, 1'b1, 1'b1, 9'd243},
      {13'd1088, 2'd3, 1'b1, 1'b1, 1'b1, 9'd242},
      {13'd1088, 2'd3, 1'b0, 1'b1, 1'b1, 9'd242},
      {13'd1088, 2'd3, 1'b1, 1'b0, 1'b1, 9'd242},
      {13'd0,    2'd0, 1'b1, 1'b1, 1'b0, 9'd242},
      {13'd63,   2'd3, 1'b1, 1'b1, 1'b1, 9'd242},
      {13'd65,   2'd3, 1'b1, 1'b1, 1'b1, 9'd241}
   };

   task automatic check_code(input logic [8:0] exp, input string tag);
      logic [LINES-1:0] texp;
      for (int i = 0; i < LINES; i++) texp[i] = (int'(exp) > i);
      checks++;
      if (code_o !== exp) begin
         fails++;
         $display("FAIL %s code_o actual %0d expected %0d", tag, code_o, exp);
      end
      checks++;
      if (reg_rdata_o !== exp) begin
         fails++;
         $display("FAIL R7 %s reg_rdata_o actual %0d expected %0d", tag, reg_rdata_o, exp);
      end
      checks++;
      if (therm_o !== texp) begin
         fails++;
         $display("FAIL R8 %s therm_o ones actual %0d expected %0d",
                  tag, $countones(therm_o), $countones(texp));
      end
   endtask

   // drive at falling edge, one rising edge, sample at next falling edge
   task automatic apply(input logic [12:0] p, input logic [1:0] s, input logic b,
                        input logic u, input logic e, input logic w, input logic [8:0] wd);
      pix_i = p; gain_sel_i = s; blk_i = b; upd_i = u; loop_en_i = e;
      reg_wr_i = w; reg_wdata_i = wd;
      @(posedge clk_i);
      @(negedge clk_i);
      upd_i = 1'b0; reg_wr_i = 1'b0; blk_i = 1'b0;
   endtask

   initial begin
      #1ms;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      check_code(9'd256, "R1 in reset");
      rst_ni = 1'b1;
      @(negedge clk_i);
      check_code(9'd256, "R1 after release");

      // table walk: R2 accumulate, R3 gain shifts and rounding, R4 qualifiers
      for (int v = 0; v < 12; v++) begin
         apply(VEC[v][26:14], VEC[v][13:12], VEC[v][11], VEC[v][10], VEC[v][9], 1'b0, '0);
         check_code(VEC[v][8:0], $sformatf("R2/R3/R4 vector %0d", v));
      end

      // large negative error: 30975 - 8127 = 22848 -> 178 (low bits nonzero)
      apply(13'd8191, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      check_code(9'd178, "R2 large error");

      // R6: write wins over simultaneous +64 update, low bits cleared
      apply(13'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 9'd100);
      check_code(9'd100, "R6 write priority");
      apply(13'd65, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      check_code(9'd99, "R6 low bits zero");

      // R4: disabled loop still takes writes, ignores updates
      apply(13'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 9'd300);
      check_code(9'd300, "R4 write while disabled");
      apply(13'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
      check_code(9'd300, "R4 update while disabled");

      // R5 upper saturation: 65408 -> 65472 -> 65535 -> 65534 -> 65278
      apply(13'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd511);
      check_code(9'd511, "R6 write full");
      apply(13'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      apply(13'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      check_code(9'd511, "R5 clip high");
      apply(13'd65, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      check_code(9'd511, "R5 no wrap high");
      apply(13'd320, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      check_code(9'd509, "R5 from saturated top");

      // R5 lower saturation: 0 -> clip 0 -> 64 -> 128
      apply(13'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0);
      check_code(9'd0, "R6 write zero");
      apply(13'd8191, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      check_code(9'd0, "R5 clip low");
      apply(13'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      apply(13'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, '0);
      check_code(9'd1, "R5 no wrap low");

      // R1: reset mid-run returns to mid-scale
      rst_ni = 1'b0;
      @(negedge clk_i);
      check_code(9'd256, "R1 reset mid-run");
      rst_ni = 1'b1;
      @(negedge clk_i);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule